// File: doc/BRIEF.md
# Circular and Bit-Reverse Operand Address Generator

This block produces one memory operand address per clock from a set of pointer registers. Each pointer set holds four 32-bit values: an index (the current pointer), a signed modifier (the step), a length and a base. A request names one pointer set and an addressing mode. The block registers the resulting address and, in most modes, steps the index so the next request to the same set continues the walk. The address generator runs beside the arithmetic units, so a new request can be accepted on every cycle.

Four modes are supported. Linear post-modify emits the index and then adds the modifier. Circular mode does the same, but keeps the index inside a ring buffer `[base, base+length)` that may sit at any address. Bit-reverse mode emits the index with its low N bits mirrored, for FFT data reordering. Base-relative mode emits base plus index and leaves the index unchanged.

The pointer sets are held twice, in a primary and a shadow bank. A single bank-select bit switches every request over to the other copy for fast context switches. The register write port can load either bank at any time.

Top module: `dag_top`

## Requirements
- R1: After reset `addr_vld` is 0, `addr` is 0, the selected bank is the primary bank (0), and every index, modifier, length and base register in both banks is 0.
- R2: Mode code 0 (linear) emits the index as the address, then sets the index to index + modifier, with the modifier taken as two's complement and the sum wrapping modulo 2^32.
- R3: Mode code 1 (circular) with a non-zero length emits the index, then sets index + modifier. If that sum is at or above base + length, length is subtracted from it.
- R4: Mode code 1 with a non-zero length: if index + modifier falls below base, length is added to it. This holds for the case where the modifier magnitude is smaller than the length and the index starts in the buffer.
- R5: Mode code 1 with length 0 performs no wrapping and behaves exactly as linear post-modify (R2), whatever the base.
- R6: Mode code 2 (bit-reverse) emits the index with bits [N-1:0] reversed (bit i takes bit N-1-i) and all other bits unchanged. N comes from `req_rev`; values above 16 act as 16 and 0 means no reversal. The index then advances by the modifier with no wrap.
- R7: Mode code 3 (base-relative) emits base + index and leaves the index unchanged.
- R8: The address for a request made in cycle t appears on `addr` with `addr_vld` high in cycle t+1. Requests may be issued on consecutive cycles. `addr_vld` is low in any cycle that follows a cycle without a request.
- R9: `bank_we` loads `bank_val` as the active bank, and the change applies from the next request onward; a request issued in the same cycle still uses the old bank. Requests only read and step the active bank, so the inactive bank keeps its contents.
- R10: When a write to an index and a request that steps that same index (same bank and pointer set) fall in the same cycle, the written value is kept. The request's address still comes from the old index. A write to the other bank does not disturb the request.
- R11: `wr_field` selects the register written: 0 index, 1 modifier, 2 length, 3 base. `wr_bank` picks the bank and `wr_sel` the pointer set; each write takes effect at the clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_bank | input | 1 | Bank targeted by the write |
| wr_sel | input | $clog2(NBUF) | Pointer set targeted by the write |
| wr_field | input | 2 | Register within the set (R11 encoding) |
| wr_data | input | 32 | Write value |
| bank_we | input | 1 | Load the active-bank selector |
| bank_val | input | 1 | New active bank |
| req_valid | input | 1 | Address request |
| req_sel | input | $clog2(NBUF) | Pointer set used by the request |
| req_mode | input | 2 | Addressing mode code (0 linear, 1 circular, 2 bit-reverse, 3 base-relative) |
| req_rev | input | 5 | Number of low bits reversed in mode 2 |
| addr_vld | output | 1 | Address output valid |
| addr | output | 32 | Generated operand address |

## Verification
The bench builds the block with NBUF = 4, so each bank has four pointer sets. This is enough to mix pointer sets, address both banks and place same-cycle write and request collisions, while keeping the storage small. For every ring length from 1 to 8, the bench sweeps every modifier of smaller magnitude in both directions and walks twice around the ring, so wrap-up and wrap-down are checked at each position. The reverse width is swept from 0 past the 16-bit clamp, and the linear mode is driven across the 2^32 wrap.

// File: rtl/dag_pkg.sv
package dag_pkg;

    localparam int ADDR_W  = 32;
    localparam int REV_MAX = 16;
    localparam int REV_W   = $clog2(REV_MAX + 1);
    localparam int NBANK   = 2;

    typedef enum logic [1:0] {
        AM_POST = 2'd0,
        AM_CIRC = 2'd1,
        AM_BREV = 2'd2,
        AM_BOFS = 2'd3
    } amode_e;

    typedef enum logic [1:0] {
        FLD_IDX  = 2'd0,
        FLD_MOD  = 2'd1,
        FLD_LEN  = 2'd2,
        FLD_BASE = 2'd3
    } fld_e;

    typedef struct packed {
        logic [ADDR_W-1:0] idx;
        logic [ADDR_W-1:0] mod;
        logic [ADDR_W-1:0] len;
        logic [ADDR_W-1:0] base;
    } dag_regs_t;

    // Mirror the low n bits of v; n is clamped to REV_MAX.
    function automatic logic [ADDR_W-1:0] bit_rev(input logic [ADDR_W-1:0] v,
                                                  input logic [REV_W-1:0]  n);
        logic [ADDR_W-1:0] r;
        logic [REV_W-1:0]  m;
        r = v;
        m = (n > REV_W'(REV_MAX)) ? REV_W'(REV_MAX) : n;
        for (int i = 0; i < REV_MAX; i++) begin
            if (REV_W'(i) < m) r[i] = v[m - REV_W'(i) - REV_W'(1)];
        end
        return r;
    endfunction

endpackage

// File: rtl/dag_regbank.sv
module dag_regbank
    import dag_pkg::*;
#(
    parameter int NBUF = 16,
    localparam int SW  = $clog2(NBUF)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [SW-1:0]     wr_sel,
    input  fld_e              wr_fld,
    input  logic [ADDR_W-1:0] wr_data,
    input  logic              upd_en,
    input  logic [SW-1:0]     upd_sel,
    input  logic [ADDR_W-1:0] upd_idx,
    input  logic [SW-1:0]     rd_sel,
    output dag_regs_t         rd
);

    dag_regs_t regs [NBUF];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NBUF; i++) regs[i] <= '0;
        end else begin
            for (int i = 0; i < NBUF; i++) begin
                if (wr_en && wr_sel == SW'(i)) begin
                    case (wr_fld)
                        FLD_MOD:  regs[i].mod  <= wr_data;
                        FLD_LEN:  regs[i].len  <= wr_data;
                        FLD_BASE: regs[i].base <= wr_data;
                        default:  ;
                    endcase
                end
                // write port outranks the post-modify update
                if (wr_en && wr_sel == SW'(i) && wr_fld == FLD_IDX)
                    regs[i].idx <= wr_data;
                else if (upd_en && upd_sel == SW'(i))
                    regs[i].idx <= upd_idx;
            end
        end
    end

    assign rd = regs[rd_sel];

endmodule

// File: rtl/dag_addr_calc.sv
module dag_addr_calc
    import dag_pkg::*;
(
    input  dag_regs_t         cur,
    input  amode_e            mode,
    input  logic [REV_W-1:0]  rev_n,
    output logic [ADDR_W-1:0] addr_out,
    output logic [ADDR_W-1:0] nxt_idx,
    output logic              steps
);

    logic [ADDR_W-1:0] sum;
    logic [ADDR_W-1:0] lim;
    logic [ADDR_W-1:0] ring;

    always_comb begin
        sum = cur.idx + cur.mod;
        lim = cur.base + cur.len;
        if (cur.len == '0)     ring = sum;
        else if (sum >= lim)   ring = sum - cur.len;
        else if (sum < cur.base) ring = sum + cur.len;
        else                   ring = sum;
    end

    always_comb begin
        steps    = 1'b1;
        nxt_idx  = sum;
        addr_out = cur.idx;
        case (mode)
            AM_CIRC: nxt_idx  = ring;
            AM_BREV: addr_out = bit_rev(cur.idx, rev_n);
            AM_BOFS: begin
                addr_out = cur.base + cur.idx;
                nxt_idx  = cur.idx;
                steps    = 1'b0;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/dag_top.sv
module dag_top
    import dag_pkg::*;
#(
    parameter int NBUF = 16,
    localparam int SW  = $clog2(NBUF)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              wr_bank,
    input  logic [SW-1:0]     wr_sel,
    input  logic [1:0]        wr_field,
    input  logic [ADDR_W-1:0] wr_data,
    input  logic              bank_we,
    input  logic              bank_val,
    input  logic              req_valid,
    input  logic [SW-1:0]     req_sel,
    input  logic [1:0]        req_mode,
    input  logic [REV_W-1:0]  req_rev,
    output logic              addr_vld,
    output logic [ADDR_W-1:0] addr
);

    logic              act_bank;
    dag_regs_t         bank_rd [NBANK];
    dag_regs_t         cur;
    logic [ADDR_W-1:0] calc_addr;
    logic [ADDR_W-1:0] nxt_idx;
    logic              steps;

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        dag_regbank #(.NBUF(NBUF)) u_bank (
            .clk     (clk),
            .rst     (rst),
            .wr_en   (wr_en && wr_bank == 1'(b)),
            .wr_sel  (wr_sel),
            .wr_fld  (fld_e'(wr_field)),
            .wr_data (wr_data),
            .upd_en  (req_valid && steps && act_bank == 1'(b)),
            .upd_sel (req_sel),
            .upd_idx (nxt_idx),
            .rd_sel  (req_sel),
            .rd      (bank_rd[b])
        );
    end

    assign cur = bank_rd[act_bank];

    dag_addr_calc u_calc (
        .cur      (cur),
        .mode     (amode_e'(req_mode)),
        .rev_n    (req_rev),
        .addr_out (calc_addr),
        .nxt_idx  (nxt_idx),
        .steps    (steps)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            act_bank <= 1'b0;
            addr_vld <= 1'b0;
            addr     <= '0;
        end else begin
            if (bank_we) act_bank <= bank_val;
            addr_vld <= req_valid;
            if (req_valid) addr <= calc_addr;
        end
    end

endmodule

// File: rtl/dag_chk.sv
module dag_chk
    import dag_pkg::*;
#(
    parameter int NBUF = 16,
    localparam int SW  = $clog2(NBUF)
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic [1:0]        req_mode,
    input logic [SW-1:0]     req_sel,
    input logic              wr_en,
    input logic              bank_we,
    input logic              bank_val,
    input logic              addr_vld,
    input logic [ADDR_W-1:0] addr,
    input dag_regs_t         cur,
    input logic [ADDR_W-1:0] nxt_idx,
    input logic              act_bank
);

    logic [ADDR_W-1:0] mod_mag;
    logic              circ_in;
    logic              prev_bofs;
    logic [SW-1:0]     prev_sel;

    always_comb begin
        mod_mag = cur.mod[ADDR_W-1] ? (~cur.mod + 1'b1) : cur.mod;
        circ_in = req_valid && req_mode == AM_CIRC && cur.len != '0 &&
                  (cur.idx - cur.base) < cur.len && mod_mag < cur.len;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_bofs <= 1'b0;
            prev_sel  <= '0;
        end else begin
            prev_bofs <= req_valid && req_mode == AM_BOFS && !wr_en && !bank_we;
            prev_sel  <= req_sel;
        end
    end

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (!addr_vld && addr == '0));

    // R8
    issue_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> addr_vld);

    // R8
    idle_chk: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !addr_vld);

    // R3
    ring_window_chk: assert property (@(posedge clk) disable iff (rst)
        circ_in |-> ((nxt_idx - cur.base) < cur.len));

    // R6
    brev_upper_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_mode == AM_BREV)
        |=> addr[ADDR_W-1:REV_MAX] == $past(cur.idx[ADDR_W-1:REV_MAX]));

    // R7
    bofs_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (prev_bofs && req_valid && req_mode == AM_BOFS && req_sel == prev_sel &&
         !wr_en && !bank_we) |=> addr == $past(addr));

    // R9
    bank_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !bank_we |=> $stable(act_bank));

    // R9
    bank_load_chk: assert property (@(posedge clk) disable iff (rst)
        bank_we |=> act_bank == $past(bank_val));

endmodule

bind dag_top dag_chk #(.NBUF(NBUF)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_mode  (req_mode),
    .req_sel   (req_sel),
    .wr_en     (wr_en),
    .bank_we   (bank_we),
    .bank_val  (bank_val),
    .addr_vld  (addr_vld),
    .addr      (addr),
    .cur       (cur),
    .nxt_idx   (nxt_idx),
    .act_bank  (act_bank)
);

// File: tb/sim_dag_top.sv
module sim_dag_top;

    localparam int CLK_PERIOD = 10;
    localparam int NBUF       = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic        wr_bank = 1'b0;
    logic [1:0]  wr_sel = '0;
    logic [1:0]  wr_field = '0;
    logic [31:0] wr_data = '0;
    logic        bank_we = 1'b0;
    logic        bank_val = 1'b0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_sel = '0;
    logic [1:0]  req_mode = '0;
    logic [4:0]  req_rev = '0;
    logic        addr_vld;
    logic [31:0] addr;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dag_top #(.NBUF(NBUF)) u0 (
        .clk, .rst, .wr_en, .wr_bank, .wr_sel, .wr_field, .wr_data,
        .bank_we, .bank_val, .req_valid, .req_sel, .req_mode, .req_rev,
        .addr_vld, .addr
    );

    task automatic chk(input string tag, input logic [31:0] exp);
        checks++;
        if (!(addr_vld === 1'b1 && addr === exp)) begin
            errors++;
            $display("FAIL %s addr=%h vld=%b expected addr=%h vld=1", tag, addr, addr_vld, exp);
        end
    endtask

    task automatic wr(input logic b, input logic [1:0] s, input logic [1:0] f,
                      input logic [31:0] d);
        wr_en = 1'b1; wr_bank = b; wr_sel = s; wr_field = f; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic do_req(input logic [1:0] s, input logic [1:0] m, input logic [4:0] n);
        req_valid = 1'b1; req_sel = s; req_mode = m; req_rev = n;
        @(negedge clk);
        req_valid = 1'b0; bank_we = 1'b0; wr_en = 1'b0;
    endtask

    function automatic logic [31:0] mirror(input logic [31:0] v, input int n);
        logic [31:0] r = v;
        int m = (n > 16) ? 16 : n;
        for (int i = 0; i < m; i++) r[i] = v[m-1-i];
        return r;
    endfunction

    initial begin
        logic [31:0] e_idx, e_sum, base, mv;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state at the ports, registers read back as zero
        checks++;
        if (addr_vld !== 1'b0 || addr !== '0) begin
            errors++;
            $display("FAIL R1 addr=%h vld=%b expected addr=0 vld=0", addr, addr_vld);
        end
        do_req(2'd0, 2'd1, 5'd0); chk("R1", 32'h0);
        do_req(2'd3, 2'd3, 5'd0); chk("R1", 32'h0);

        // R2 / R11: linear post-modify, both signs, 32-bit wrap
        wr(1'b0, 2'd1, 2'd0, 32'd100);
        wr(1'b0, 2'd1, 2'd1, 32'd5);
        e_idx = 32'd100;
        for (int k = 0; k < 3; k++) begin
            do_req(2'd1, 2'd0, 5'd0); chk("R11_R2", e_idx); e_idx += 32'd5;
        end
        wr(1'b0, 2'd1, 2'd1, 32'hFFFF_FFFD);
        do_req(2'd1, 2'd0, 5'd0); chk("R2", 32'd115);
        do_req(2'd1, 2'd0, 5'd0); chk("R2", 32'd112);
        wr(1'b0, 2'd1, 2'd0, 32'hFFFF_FFFE);
        wr(1'b0, 2'd1, 2'd1, 32'd3);
        do_req(2'd1, 2'd0, 5'd0); chk("R2", 32'hFFFF_FFFE);
        do_req(2'd1, 2'd0, 5'd0); chk("R2", 32'h0000_0001);

        // R3 / R4: ring sweep over lengths and modifiers
        for (int ln = 1; ln <= 8; ln++) begin
            for (int md = -(ln-1); md <= ln-1; md++) begin
                base = 32'h1000 + 32'(ln*64);
                mv   = 32'(md);
                wr(1'b0, 2'd1, 2'd3, base);
                wr(1'b0, 2'd1, 2'd2, 32'(ln));
                wr(1'b0, 2'd1, 2'd1, mv);
                wr(1'b0, 2'd1, 2'd0, base + 32'(ln-1));
                e_idx = base + 32'(ln-1);
                for (int k = 0; k < 2*ln; k++) begin
                    do_req(2'd1, 2'd1, 5'd0);
                    chk(md >= 0 ? "R3" : "R4", e_idx);
                    e_sum = e_idx + mv;
                    if (e_sum >= base + 32'(ln)) e_sum -= 32'(ln);
                    else if (e_sum < base)       e_sum += 32'(ln);
                    e_idx = e_sum;
                end
            end
        end

        // R5: zero length, no wrap even below base
        wr(1'b0, 2'd0, 2'd3, 32'd50);
        wr(1'b0, 2'd0, 2'd2, 32'd0);
        wr(1'b0, 2'd0, 2'd0, 32'd10);
        wr(1'b0, 2'd0, 2'd1, 32'd7);
        do_req(2'd0, 2'd1, 5'd0); chk("R5", 32'd10);
        do_req(2'd0, 2'd1, 5'd0); chk("R5", 32'd17);
        do_req(2'd0, 2'd1, 5'd0); chk("R5", 32'd24);

        // R6: reverse widths 0..20, clamp at 16
        wr(1'b0, 2'd2, 2'd0, 32'h1234_5678);
        wr(1'b0, 2'd2, 2'd1, 32'h0001_0003);
        e_idx = 32'h1234_5678;
        for (int n = 0; n <= 20; n++) begin
            do_req(2'd2, 2'd2, 5'(n)); chk("R6", mirror(e_idx, n));
            e_idx += 32'h0001_0003;
        end

        // R7: base-relative, index held
        wr(1'b0, 2'd0, 2'd3, 32'h4000);
        wr(1'b0, 2'd0, 2'd0, 32'h20);
        wr(1'b0, 2'd0, 2'd1, 32'd4);
        do_req(2'd0, 2'd3, 5'd0); chk("R7", 32'h4020);
        do_req(2'd0, 2'd3, 5'd0); chk("R7", 32'h4020);
        do_req(2'd0, 2'd0, 5'd0); chk("R7", 32'h20);

        // R9: bank switch timing and retention
        wr(1'b1, 2'd2, 2'd0, 32'd777);
        wr(1'b0, 2'd2, 2'd0, 32'd333);
        wr(1'b0, 2'd2, 2'd1, 32'd0);
        do_req(2'd2, 2'd0, 5'd0); chk("R9", 32'd333);
        bank_we = 1'b1; bank_val = 1'b1;
        do_req(2'd2, 2'd0, 5'd0); chk("R9", 32'd333);
        do_req(2'd2, 2'd0, 5'd0); chk("R9", 32'd777);
        bank_we = 1'b1; bank_val = 1'b0;
        do_req(2'd2, 2'd0, 5'd0); chk("R9", 32'd777);
        do_req(2'd2, 2'd0, 5'd0); chk("R9", 32'd333);

        // R10: same-cycle write beats the post-modify
        wr(1'b0, 2'd3, 2'd1, 32'd1);
        wr(1'b0, 2'd3, 2'd0, 32'd40);
        wr_en = 1'b1; wr_bank = 1'b0; wr_sel = 2'd3; wr_field = 2'd0; wr_data = 32'd90;
        do_req(2'd3, 2'd0, 5'd0); chk("R10", 32'd40);
        do_req(2'd3, 2'd0, 5'd0); chk("R10", 32'd90);
        wr_en = 1'b1; wr_bank = 1'b1; wr_sel = 2'd3; wr_field = 2'd0; wr_data = 32'd5;
        do_req(2'd3, 2'd0, 5'd0); chk("R10", 32'd91);
        do_req(2'd3, 2'd0, 5'd0); chk("R10", 32'd92);

        // R8: valid drops after an idle cycle
        @(negedge clk);
        checks++;
        if (addr_vld !== 1'b0) begin
            errors++;
            $display("FAIL R8 vld=%b expected vld=0", addr_vld);
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired act=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule